// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a serial slave that lets an external controller read and write a bank of sixteen 8-bit control registers. It uses an active-low enable, a serial clock and one data line. The data line is split at the block boundary into an input, an output and an output-enable, so the pad's tristate buffer sits outside the block. Every frame has sixteen bit slots. The first carries the read/write flag, the next three carry a device ID, then come a 4-bit register address and an 8-bit data byte. All fields are sent most significant bit first.

The enable, the serial clock and the incoming data bit each pass through a two-flop synchronizer clocked by the system clock. Clock edges are detected in the system clock domain. One bit of register 5 selects which serial clock edge latches incoming bits, and the edge used to drive read data follows from it. The register contents are always visible on a flat parallel output for the logic they configure.

Top module: `serRegPort`

## Requirements
- R1: After reset all sixteen registers read zero, inverted mode is off and the data line is not driven (`sdataOe` = 0).
- R2: A frame begins at a falling edge of `senN`. Its successive active clock edges carry, in order, R/W (0 = write, 1 = read), a 3-bit ID, a 4-bit address and an 8-bit data byte, with every field sent MSB first.
- R3: A write frame with ID 3'b111 updates the addressed register on its 16th active edge. The update lands in `regOut[addr*8 +: 8]` and no other register changes.
- R4: A frame whose ID is not 3'b111 changes no register and never asserts `sdataOe`.
- R5: If `senN` rises before the 16th active edge of a write frame, the write is discarded.
- R6: In default mode (register 5 bit 7 = 0), bits are latched on falling clock edges. On a read, the line is taken with data bit 7 at the first rising edge after the 8th falling edge. Each falling edge from the 9th onward moves the line to the next lower bit.
- R7: In inverted mode (register 5 bit 7 = 1), bits are latched on rising clock edges. On a read, the line is taken with data bit 7 at the first falling edge after the 8th rising edge. Each rising edge from the 10th onward presents the next lower bit, so the controller samples every bit on a falling edge.
- R8: The mode is taken from register 5 bit 7 when `senN` falls and is held for the whole frame. It changes only through a committed write to that bit, which uses the protocol of the mode in force.
- R9: Once taken, the line stays driven with no gap until `senN` rises. It is released within four system clocks of that rise.
- R10: Every falling edge of `senN` restarts bit counting, so a complete frame that follows an aborted one decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| senN | input | 1 | Serial enable, active low |
| sclk | input | 1 | Serial clock from the controller |
| sdataIn | input | 1 | Data line value seen at the pad |
| sdataOut | output | 1 | Data bit driven during reads |
| sdataOe | output | 1 | Output enable for the data line pad |
| regOut | output | 128 | All registers, register n at bits n*8+7 down to n*8 |

## Verification
Reads and writes are run at the lowest address, the highest address and a middle address. Byte patterns with a single set bit at either end, plus alternating and mixed values, expose any reversal of bit order or an off-by-one in the count. Every register is then written with a distinct value and read back in inverted mode, which separates address decoding from data handling. Frames with a wrong ID, and writes cut short at 12 and 15 edges, must leave the bank and the data line untouched. The mode bit is set and then cleared, each time through the protocol in force, and a default-mode read must succeed afterwards.

// File: rtl/serRegPkg.sv
package serRegPkg;
  localparam int NUM_REGS    = 16;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = $clog2(NUM_REGS);
  localparam int ID_W        = 3;
  localparam logic [ID_W-1:0] DEV_ID = '1;
  localparam int HDR_W       = 1 + ID_W + ADDR_W;
  localparam int FRAME_EDGES = HDR_W + DATA_W;
  localparam int CNT_W       = $clog2(FRAME_EDGES + 1);
  localparam int MODE_REG    = 5;
  localparam int MODE_BIT    = 7;

  // Strobes from the frame controller to the register datapath
  typedef struct packed {
    logic              loadOut;
    logic              shiftOut;
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wrData;
  } strobes_t;
endpackage

// File: rtl/serRegSync.sv
module serRegSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/serRegCtrl.sv
module serRegCtrl
  import serRegPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     senS,
  input  logic     sclkS,
  input  logic     sdaS,
  input  logic     invMode,
  output strobes_t str,
  output logic     sdataOe
);
  localparam logic [CNT_W-1:0] HDR_EDGE  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(FRAME_EDGES);
  localparam logic [CNT_W-1:0] SPAN      = CNT_W'(DATA_W - 2);

  logic              sclkPrev, senPrev, inFrame, frameInv, armed;
  logic [CNT_W-1:0]  edgeCnt, nextCnt, shiftFirst, shiftLast;
  logic [HDR_W-1:0]  hdr, hdrNext;
  logic [DATA_W-2:0] dataSh;
  logic sclkRise, sclkFall, senFall, activeEdge, driveEdge, takeEdge;
  logic isRead, idOk, wrIdOk;

  assign sclkRise   = sclkS & ~sclkPrev;
  assign sclkFall   = ~sclkS & sclkPrev;
  assign senFall    = ~senS & senPrev;
  assign activeEdge = frameInv ? sclkRise : sclkFall;
  assign driveEdge  = frameInv ? sclkFall : sclkRise;
  assign takeEdge   = inFrame && activeEdge && (edgeCnt < LAST_EDGE);
  assign nextCnt    = edgeCnt + 1'b1;
  assign hdrNext    = {hdr[HDR_W-2:0], sdaS};
  assign isRead     = hdrNext[HDR_W-1];
  assign idOk       = (hdrNext[ADDR_W +: ID_W] == DEV_ID);
  assign wrIdOk     = !hdr[HDR_W-1] && (hdr[ADDR_W +: ID_W] == DEV_ID);
  assign shiftFirst = frameInv ? HDR_EDGE + CNT_W'(2) : HDR_EDGE + CNT_W'(1);
  assign shiftLast  = shiftFirst + SPAN;

  always_comb begin
    str        = '0;
    str.addr   = hdrNext[ADDR_W-1:0];
    str.wrData = {dataSh, sdaS};
    if (takeEdge) begin
      if (nextCnt == HDR_EDGE && isRead && idOk) str.loadOut = 1'b1;
      if (sdataOe && nextCnt >= shiftFirst && nextCnt <= shiftLast) str.shiftOut = 1'b1;
      if (nextCnt == LAST_EDGE && wrIdOk) begin
        str.wrEn = 1'b1;
        str.addr = hdr[ADDR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      senPrev  <= 1'b1;
      inFrame  <= 1'b0;
      frameInv <= 1'b0;
      armed    <= 1'b0;
      sdataOe  <= 1'b0;
      edgeCnt  <= '0;
      hdr      <= '0;
      dataSh   <= '0;
    end else begin
      sclkPrev <= sclkS;
      senPrev  <= senS;
      if (senS) begin
        inFrame <= 1'b0;
        armed   <= 1'b0;
        sdataOe <= 1'b0;
      end else if (senFall) begin
        inFrame  <= 1'b1;
        frameInv <= invMode;
        armed    <= 1'b0;
        sdataOe  <= 1'b0;
        edgeCnt  <= '0;
        hdr      <= '0;
        dataSh   <= '0;
      end else if (takeEdge) begin
        edgeCnt <= nextCnt;
        if (nextCnt <= HDR_EDGE) hdr <= hdrNext;
        else dataSh <= str.wrData[DATA_W-2:0];
        if (nextCnt == HDR_EDGE) armed <= isRead && idOk;
      end else if (inFrame && driveEdge && armed) begin
        sdataOe <= 1'b1;
        armed   <= 1'b0;
      end
    end
  end

  // R9: a high enable releases the line on the next clock
  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    senS |=> !sdataOe);
  // R9: no gap while the enable stays low
  assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sdataOe && !senS) |=> sdataOe);
  // R6/R7: takeover only after the full header and before the 9th edge
  assert_takeover_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdataOe) |-> (edgeCnt == HDR_EDGE));
  // R8: the mode is frozen for the duration of a frame
  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inFrame && !senS && !senFall) |=> $stable(frameInv));
endmodule

// File: rtl/serRegBank.sv
module serRegBank
  import serRegPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   str,
  output logic                       sdataOut,
  output logic                       invMode,
  output logic [NUM_REGS*DATA_W-1:0] regOut
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] outSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      outSh <= '0;
    end else begin
      if (str.wrEn) regs[str.addr] <= str.wrData;
      if (str.loadOut) outSh <= regs[str.addr];
      else if (str.shiftOut) outSh <= {outSh[DATA_W-2:0], 1'b0};
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gOut
    assign regOut[g*DATA_W +: DATA_W] = regs[g];
  end

  assign sdataOut = outSh[DATA_W-1];
  assign invMode  = regs[MODE_REG][MODE_BIT];

  // R3: without a write strobe the bank holds its contents
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !str.wrEn |=> $stable(regOut));
  // R5: one commit per frame, never on consecutive clocks
  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    str.wrEn |=> !str.wrEn);
endmodule

// File: rtl/serRegPort.sv
module serRegPort
  import serRegPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       senN,
  input  logic                       sclk,
  input  logic                       sdataIn,
  output logic                       sdataOut,
  output logic                       sdataOe,
  output logic [NUM_REGS*DATA_W-1:0] regOut
);
  logic [2:0] syncBits;
  logic       invMode;
  strobes_t   str;

  serRegSync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({senN, sclk, sdataIn}),
    .syncOut(syncBits)
  );

  serRegCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .senS(syncBits[2]), .sclkS(syncBits[1]), .sdaS(syncBits[0]),
    .invMode(invMode), .str(str), .sdataOe(sdataOe)
  );

  serRegBank uBank (
    .clk(clk), .rstN(rstN), .str(str),
    .sdataOut(sdataOut), .invMode(invMode), .regOut(regOut)
  );
endmodule

// File: tb/tb_serRegPort.sv
module tb_serRegPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic senN = 1'b1, sclk = 1'b1, sdataIn = 1'b0;
  logic sdataOut, sdataOe;
  logic [127:0] regOut;

  serRegPort dut (.clk(clk), .rstN(rstN), .senN(senN), .sclk(sclk),
                  .sdataIn(sdataIn), .sdataOut(sdataOut), .sdataOe(sdataOe),
                  .regOut(regOut));

  always #10 clk = ~clk;

  int nCmp = 0, nBad = 0;
  bit invM = 1'b0, oeFlag = 1'b0, done = 1'b0;
  logic [7:0] mdl [16];
  logic [7:0] expQ[$], gotQ[$];
  string tagQ[$];

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mdlFlat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  task automatic half();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      oeFlag |= sdataOe;
    end
  endtask

  task automatic frame(input bit rw, input logic [2:0] id, input logic [3:0] addr,
                       input logic [7:0] wd, input int nEdges, output logic [7:0] rd);
    logic [15:0] bits;
    bits = {rw, id, addr, wd};
    rd = '0;
    oeFlag = 1'b0;
    sclk = invM ? 1'b0 : 1'b1;
    half();
    senN = 1'b0;
    half();
    for (int e = 1; e <= nEdges; e++) begin
      sdataIn = bits[16-e];
      half();
      if (!invM) begin
        if (e >= 9) rd[16-e] = sdataOut;
        sclk = 1'b0; half(); sclk = 1'b1;
      end else begin
        sclk = 1'b1; half();
        if (e >= 9) rd[16-e] = sdataOut;
        sclk = 1'b0;
      end
    end
    half();
    senN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(string req, input logic [2:0] id, input logic [3:0] addr,
                    input logic [7:0] d, input int nEdges);
    logic [7:0] dummy;
    frame(1'b0, id, addr, d, nEdges, dummy);
    if (id == 3'b111 && nEdges >= 16) begin
      mdl[addr] = d;
      if (addr == 4'd5) invM = d[7];
    end
    chk(req, "register bank", regOut, mdlFlat());
  endtask

  task automatic rdReg(string req, input logic [2:0] id, input logic [3:0] addr);
    logic [7:0] got;
    bit seen;
    frame(1'b1, id, addr, 8'h00, 16, got);
    seen = oeFlag;
    if (id == 3'b111) begin
      expQ.push_back(mdl[addr]);
      tagQ.push_back(req);
      gotQ.push_back(got);
      chk(req, "line taken", {127'd0, seen}, 128'd1);
    end else begin
      chk("R4", "line driven on foreign ID", {127'd0, seen}, 128'd0);
    end
    chk("R9", "line released after enable", {127'd0, sdataOe}, 128'd0);
  endtask

  // Monitor: pops expected read bytes and compares as results arrive
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0) begin
        logic [7:0] g, x;
        string t;
        g = gotQ.pop_front();
        x = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, "read data", {120'd0, g}, {120'd0, x});
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "reset bank", regOut, 128'd0);
    chk("R1", "reset line", {127'd0, sdataOe}, 128'd0);

    // default mode, field order and bit order
    wr("R2", 3'b111, 4'd3, 8'hA5, 16);
    rdReg("R6", 3'b111, 4'd3);
    wr("R3", 3'b111, 4'd0, 8'h01, 16);
    wr("R3", 3'b111, 4'd15, 8'h80, 16);
    rdReg("R6", 3'b111, 4'd0);
    rdReg("R6", 3'b111, 4'd15);

    // foreign ID is ignored
    wr("R4", 3'b110, 4'd4, 8'hFF, 16);
    wr("R4", 3'b011, 4'd3, 8'h00, 16);
    rdReg("R4", 3'b011, 4'd3);

    // aborted writes, then a clean frame
    wr("R5", 3'b111, 4'd4, 8'h77, 12);
    wr("R5", 3'b111, 4'd4, 8'h77, 15);
    wr("R10", 3'b111, 4'd4, 8'h4E, 16);
    rdReg("R10", 3'b111, 4'd4);

    // switch to inverted mode through the default protocol
    wr("R8", 3'b111, 4'd5, 8'h80, 16);
    rdReg("R7", 3'b111, 4'd5);
    wr("R7", 3'b111, 4'd9, 8'h3C, 16);
    rdReg("R7", 3'b111, 4'd9);
    rdReg("R7", 3'b111, 4'd3);
    rdReg("R4", 3'b101, 4'd9);

    // every register in inverted mode
    for (int a = 0; a < 16; a++) begin
      if (a != 5) wr("R7", 3'b111, 4'(a), 8'(a * 17) ^ 8'h5A, 16);
    end
    for (int a = 0; a < 16; a++) rdReg("R7", 3'b111, 4'(a));

    // back to default through the inverted protocol
    wr("R8", 3'b111, 4'd5, 8'h00, 16);
    rdReg("R8", 3'b111, 4'd15);
    rdReg("R6", 3'b111, 4'd9);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule